// File: doc/BRIEF.md
# Flash and Torch Mode Controller

This block is the control core of a white-LED driver. It takes the command-register bits (power, trigger enable, torch, temperature-monitor enable) and two 4-bit dimming codes. It also takes a hardware trigger pin, a transmit-mask pin and an abort strobe from an external safety timer. From these it selects one operating mode: off, ready, torch or flash. It also produces the 4-bit current code that the analog regulator applies, plus enables for the analog section and the LED temperature monitor.

A flash fires when the trigger pin and an armed copy of the trigger-enable bit are both high. Software can therefore trigger by holding the pin high and writing the bit. A processor can instead trigger in hardware by setting the bit in advance and pulsing the pin. Flash outranks torch. When the flash request goes away, the mode falls back to torch if the torch bit is still set, and to ready otherwise. The two pins pass through synchronizers. The mode and the current code are registered together, so they always change on the same edge. All interfaces are plain control levels and carry no valid/ready handshake.

Top module: `ledctl_top`

## Requirements
- R1: Flash is requested only when the synchronized trigger pin is 1 and the armed trigger-enable copy is 1. The copy arms one edge after the trigger-enable bit goes from 0 to 1, and disarms whenever the bit is 0.
- R2: While the power bit is 0, the mode is off (code 0), analog_en is 0, mon_en is 0, and no flash can start.
- R3: With power on and no flash request, a set torch bit gives torch mode, and cur_code equals the torch dimming code.
- R4: Flash mode applies the flash dimming code. Flash takes priority over torch. When the request drops, the mode returns to torch if the torch bit is set, and to ready otherwise.
- R5: In flash mode, with the synchronized mask pin high and flash-code bit 3 equal to 1, cur_code is forced to CLAMP_CODE (default 7, the torch-level maximum). Flash codes with bit 3 equal to 0, and torch mode, are not affected by the mask.
- R6: In ready mode, mon_en follows the monitor-enable bit. In torch and flash modes, mon_en is 1 regardless of that bit. analog_en is 1 in every mode except off.
- R7: A cycle with timer_abort high leaves flash on the next edge and disarms the trigger-enable copy. Flash stays off until the trigger-enable bit is cleared and set again, even if the pin and the bit remain high.
- R8: After reset, mode is off, cur_code is 0, and analog_en and mon_en are 0.
- R9: The mode encoding is 0 off, 1 ready, 2 torch, 3 flash. A pin change reaches the mode output on the third rising edge after it, through two synchronizer flops and the mode register. The mode and cur_code update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_bit | input | 1 | Command bit: power the analog section |
| trig_en_bit | input | 1 | Command bit: enable the flash trigger |
| torch_bit | input | 1 | Command bit: request torch mode |
| mon_en_bit | input | 1 | Command bit: temperature monitor in ready mode |
| flash_code | input | 4 | Flash dimming code |
| torch_code | input | 4 | Torch dimming code |
| trig_pin | input | 1 | Asynchronous hardware trigger pin |
| txmask_pin | input | 1 | Asynchronous transmit-mask pin |
| timer_abort | input | 1 | Safety timer abort strobe |
| mode | output | 2 | Operating mode (0 off, 1 ready, 2 torch, 3 flash) |
| cur_code | output | 4 | Current code applied to the regulator |
| analog_en | output | 1 | Analog and power section enable |
| mon_en | output | 1 | LED temperature monitor enable |

## Verification
The hardest situation to reach is the disarmed state after an abort. The pin and the trigger-enable bit both stay high, yet flash must not come back. The stimulus first fires a flash, then pulses the abort for a single cycle while holding both inputs high. It waits several cycles to show that the mode stays in ready. It then clears and rewrites the enable bit to show that flash returns. A second delicate case is the exact pin-to-mode latency: the stimulus samples the mode two and three edges after a trigger edge.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_READY = 2'd1,
    MODE_TORCH = 2'd2,
    MODE_FLASH = 2'd3
  } led_mode_t;
endpackage

// File: rtl/ledctl_sync.sv
module ledctl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ledctl_arm.sv
module ledctl_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en_bit,
  input  logic abort,
  output logic armed
);
  logic en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev <= 1'b0;
      armed   <= 1'b0;
    end else begin
      en_prev <= en_bit;
      if (abort || !en_bit)        armed <= 1'b0;
      else if (en_bit && !en_prev) armed <= 1'b1;
    end
  end

  assert_abort_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !armed);
  assert_clear_disarms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_bit |=> !armed);
endmodule

// File: rtl/ledctl_codesel.sv
module ledctl_codesel
  import ledctl_pkg::*;
#(
  parameter int          CW         = 4,
  parameter logic [CW-1:0] CLAMP_CODE = 7
) (
  input  led_mode_t       mode_d,
  input  logic [CW-1:0]   flash_code,
  input  logic [CW-1:0]   torch_code,
  input  logic            mask,
  output logic [CW-1:0]   code_d
);
  localparam int HI = CW - 1;

  always_comb begin
    unique case (mode_d)
      MODE_TORCH: code_d = torch_code;
      MODE_FLASH: code_d = (mask && flash_code[HI]) ? CLAMP_CODE : flash_code;
      default:    code_d = '0;
    endcase
  end
endmodule

// File: rtl/ledctl_top.sv
module ledctl_top
  import ledctl_pkg::*;
#(
  parameter int          CW         = 4,
  parameter logic [CW-1:0] CLAMP_CODE = 7,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_on_bit,
  input  logic          trig_en_bit,
  input  logic          torch_bit,
  input  logic          mon_en_bit,
  input  logic [CW-1:0] flash_code,
  input  logic [CW-1:0] torch_code,
  input  logic          trig_pin,
  input  logic          txmask_pin,
  input  logic          timer_abort,
  output logic [1:0]    mode,
  output logic [CW-1:0] cur_code,
  output logic          analog_en,
  output logic          mon_en
);
  logic [1:0]    pins_s;
  logic          trig_s, mask_s, armed, flash_req;
  led_mode_t     mode_d, mode_q;
  logic [CW-1:0] code_d, code_q;

  ledctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({txmask_pin, trig_pin}), .sync_out(pins_s)
  );
  assign trig_s = pins_s[0];
  assign mask_s = pins_s[1];

  ledctl_arm u_arm (
    .clk(clk), .rst_n(rst_n), .en_bit(trig_en_bit),
    .abort(timer_abort), .armed(armed)
  );

  assign flash_req = trig_s && armed && !timer_abort;

  always_comb begin
    if (!pwr_on_bit)     mode_d = MODE_OFF;
    else if (flash_req)  mode_d = MODE_FLASH;
    else if (torch_bit)  mode_d = MODE_TORCH;
    else                 mode_d = MODE_READY;
  end

  ledctl_codesel #(.CW(CW), .CLAMP_CODE(CLAMP_CODE)) u_code (
    .mode_d(mode_d), .flash_code(flash_code), .torch_code(torch_code),
    .mask(mask_s), .code_d(code_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      code_q <= '0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

  assign mode      = mode_q;
  assign cur_code  = code_q;
  assign analog_en = (mode_q != MODE_OFF);
  assign mon_en    = (mode_q == MODE_TORCH) || (mode_q == MODE_FLASH) ||
                     ((mode_q == MODE_READY) && mon_en_bit);

  assert_power_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_bit |=> (mode == 2'd0) && !analog_en && (cur_code == '0));
  assert_abort_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_abort |=> (mode != 2'd3));
  assert_flash_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == 2'd3) |-> $past(armed) && $past(trig_s));
  assert_mask_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) && $past(mask_s) |-> (cur_code <= CLAMP_CODE));
  assert_monitor_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b1) |-> mon_en && analog_en);
endmodule

// File: tb/ledctl_top_tb.sv
module ledctl_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on_bit = 0, trig_en_bit = 0, torch_bit = 0, mon_en_bit = 0;
  logic [3:0] flash_code = 0, torch_code = 0;
  logic       trig_pin = 0, txmask_pin = 0, timer_abort = 0;
  logic [1:0] mode;
  logic [3:0] cur_code;
  logic       analog_en, mon_en;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ledctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_bit(pwr_on_bit), .trig_en_bit(trig_en_bit),
    .torch_bit(torch_bit), .mon_en_bit(mon_en_bit), .flash_code(flash_code),
    .torch_code(torch_code), .trig_pin(trig_pin), .txmask_pin(txmask_pin),
    .timer_abort(timer_abort), .mode(mode), .cur_code(cur_code),
    .analog_en(analog_en), .mon_en(mon_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance n edges; drive and sample 5 ns after an edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic t_reset;
    chk("R8 mode", mode, 0);
    chk("R8 code", cur_code, 0);
    chk("R8 analog_en", analog_en, 0);
    chk("R8 mon_en", mon_en, 0);
  endtask

  task automatic t_power_off;
    pwr_on_bit = 0; trig_pin = 1; trig_en_bit = 1; torch_bit = 1; mon_en_bit = 1;
    step(6);
    chk("R2 mode off", mode, 0);
    chk("R2 analog_en", analog_en, 0);
    chk("R2 mon_en", mon_en, 0);
    trig_pin = 0; trig_en_bit = 0; torch_bit = 0; mon_en_bit = 0;
    step(4);
  endtask

  task automatic t_ready_monitor;
    pwr_on_bit = 1; mon_en_bit = 0;
    step(2);
    chk("R6 ready mode", mode, 1);
    chk("R6 ready code", cur_code, 0);
    chk("R6 analog_en", analog_en, 1);
    chk("R6 mon off in ready", mon_en, 0);
    mon_en_bit = 1;
    step(1);
    chk("R6 mon follows bit", mon_en, 1);
    mon_en_bit = 0;
    step(1);
  endtask

  task automatic t_torch;
    torch_code = 4'd5; torch_bit = 1;
    step(2);
    chk("R3 torch mode", mode, 2);
    chk("R3 torch code", cur_code, 5);
    chk("R6 mon forced in torch", mon_en, 1);
    torch_code = 4'd9;
    step(1);
    chk("R3 torch code update", cur_code, 9);
  endtask

  task automatic t_soft_flash;
    // torch still on; soft trigger: pin high, then write enable
    flash_code = 4'hC; trig_pin = 1;
    step(4);
    chk("R1 pin alone no flash", mode, 2);
    trig_en_bit = 1;
    step(3);
    chk("R4 flash over torch", mode, 3);
    chk("R4 flash code", cur_code, 12);
    trig_en_bit = 0;
    step(3);
    chk("R4 back to torch", mode, 2);
    torch_bit = 0;
    step(2);
    chk("R4 back to ready", mode, 1);
    trig_pin = 0;
    step(3);
  endtask

  task automatic t_hard_latency;
    flash_code = 4'h3; trig_en_bit = 1;
    step(3);
    chk("R1 armed no pin", mode, 1);
    trig_pin = 1;
    step(2);
    chk("R9 two edges still ready", mode, 1);
    step(1);
    chk("R9 third edge flash", mode, 3);
    chk("R9 code same edge", cur_code, 3);
    trig_pin = 0;
    step(4);
    chk("R1 pin drop ends flash", mode, 1);
  endtask

  task automatic t_mask;
    flash_code = 4'hE; txmask_pin = 1; trig_pin = 1;
    step(4);
    chk("R5 mask clamps", cur_code, 7);
    txmask_pin = 0;
    step(4);
    chk("R5 mask released", cur_code, 14);
    flash_code = 4'h5; txmask_pin = 1;
    step(4);
    chk("R5 low code unaffected", cur_code, 5);
    trig_pin = 0; torch_bit = 1; torch_code = 4'hF;
    step(4);
    chk("R5 torch mode", mode, 2);
    chk("R5 torch unaffected", cur_code, 15);
    txmask_pin = 0; torch_bit = 0;
    step(3);
  endtask

  task automatic t_abort;
    flash_code = 4'h8; trig_pin = 1;
    step(4);
    chk("R7 flash before abort", mode, 3);
    timer_abort = 1;
    step(1);
    chk("R7 abort exits", mode, 1);
    timer_abort = 0;
    step(6);
    chk("R7 stays disarmed", mode, 1);
    trig_en_bit = 0;
    step(2);
    trig_en_bit = 1;
    step(3);
    chk("R7 rearm flash", mode, 3);
  endtask

  task automatic t_power_drop;
    pwr_on_bit = 0;
    step(1);
    chk("R2 drop from flash", mode, 0);
    chk("R2 drop code", cur_code, 0);
    chk("R2 drop analog", analog_en, 0);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(posedge clk); #5;
    t_reset();
    t_power_off();
    t_ready_monitor();
    t_torch();
    t_soft_flash();
    t_hard_latency();
    t_mask();
    t_abort();
    t_power_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule